// File: doc/BRIEF.md
# Packetizing Slave Write FIFO

This block is a byte-wide FIFO on the device side of a parallel interface. An external master writes bytes into it, and the block groups those bytes into packets for a downstream consumer. On every rising edge of the interface clock it samples a select, a write strobe, an end-of-packet strobe, a small FIFO address and the data bus. A write takes effect only when select is high and the address equals this instance's address. Holding the write strobe high gives a burst with one byte per edge.

Packets close in one of two ways. In auto mode, a packet closes by itself when the open byte count reaches a programmed length. In either mode, the end-of-packet strobe closes a short packet by hand. That strobe may arrive with the last byte or on any later cycle. The block ignores the strobe on the edge that completes an auto packet and on the edge right after it. Without this guard, a strobe meant to follow an auto packet could be taken as a one-byte commit too early.

Committed packets leave on a valid/ready byte stream. Every beat carries the packet's byte count, and the final beat carries a last marker. Full and empty flags, and a sticky overflow bit, report the state of the store.

Top module: `pkt_wr_fifo`

## Requirements
- R1: A byte is stored on each rising edge where `sel`, `wr_en` are high and `fifo_addr` equals `MY_ADDR`. Holding these signals for N edges stores N consecutive bytes in order.
- R2: When `sel` is low or `fifo_addr` differs from `MY_ADDR`, `wr_en` and `eop` have no effect: no byte is stored and no packet is committed.
- R3: A write on an edge where the store already holds `DEPTH` bytes is dropped. It sets `overflow`, which stays at 1 until reset. The stored count never exceeds `DEPTH`.
- R4: A manual commit (an accepted `eop` edge) creates a packet whose length is the number of uncommitted bytes, counting a byte written on that same edge. The strobe may arrive on the last data edge or on a later cycle.
- R5: An accepted `eop` with no uncommitted bytes creates a zero-length packet. It appears as a single output beat with `out_count` = 0 and `out_last` = 1.
- R6: With `auto_en` = 1, the write that brings the uncommitted count to `auto_len` commits a packet of exactly `auto_len` bytes. A value of 0 in `auto_len` never auto-commits.
- R7: `eop` is ignored on an edge that auto-commits and on the edge immediately after one. An `eop` two or more edges after the auto-commit edge commits normally, including a one-byte packet.
- R8: `full` (stored count = `DEPTH`) and `empty` (stored count = 0) are registered. They reflect the stored count of the previous cycle, so they change one cycle after the edge that changed the count. After reset, `empty` = 1 and `full` = 0.
- R9: Committed packets are emitted in commit order, with bytes in write order, on `out_valid`/`out_ready`. `out_count` holds the packet length on every beat, and `out_last` marks the final beat. While `out_valid` is high and `out_ready` is low, the outputs hold steady.
- R10: When `PKT_Q` packets are already waiting, a commit cannot be queued. A manual `eop` is then refused, and a write that would complete an auto packet is dropped. Both set `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Select; may be tied high |
| wr_en | input | 1 | Write strobe |
| eop | input | 1 | End-of-packet strobe (manual commit) |
| fifo_addr | input | ADDR_W | FIFO address; must equal MY_ADDR |
| wr_data | input | DATA_W | Write data |
| auto_en | input | 1 | Enable auto-commit at `auto_len` |
| auto_len | input | $clog2(DEPTH+1) | Auto-commit packet length |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | A committed beat is available |
| out_data | output | DATA_W | Packet byte (0 for a zero-length packet) |
| out_last | output | 1 | Final beat of the packet |
| out_count | output | $clog2(DEPTH+1) | Length of the current packet |
| full | output | 1 | Store held DEPTH bytes last cycle |
| empty | output | 1 | Store held no bytes last cycle |
| overflow | output | 1 | Sticky: dropped write or refused commit |

## Verification
The bench builds the block with `DEPTH` = 8, `PKT_Q` = 2 and `MY_ADDR` = 2. With these values a short burst fills the store, so dropped writes and the one-cycle flag lag can be observed. Three stacked commits exhaust the packet queue, which makes the refused-commit path reachable. The auto length of 4 leaves room for the one-byte packet that follows an auto packet. A stretch of randomized traffic, with a stalling consumer, mixes auto and manual commits against the bench's queue-based model.

// File: rtl/pwf_pkg.sv
package pwf_pkg;
  // width of a counter that must hold values 0..n
  function automatic int unsigned cnt_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pwf_byte_ram.sv
module pwf_byte_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pwf_len_queue.sv
module pwf_len_queue #(
  parameter int LW = 5,
  parameter int QD = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  logic          pop,
  output logic [LW-1:0] head_len,
  output logic          nonempty,
  output logic          full_o
);
  localparam int PW = (QD > 1) ? $clog2(QD) : 1;
  localparam int NW = $clog2(QD + 1);

  logic [LW-1:0] q [QD];
  logic [PW-1:0] hd, tl;
  logic [NW-1:0] n;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(QD - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) q[tl] <= push_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hd <= '0;
      tl <= '0;
      n  <= '0;
    end else begin
      if (push) tl <= nxt(tl);
      if (pop)  hd <= nxt(hd);
      n <= n + NW'(push) - NW'(pop);
    end
  end

  assign head_len = q[hd];
  assign nonempty = (n != '0);
  assign full_o   = (n == NW'(QD));

  p_no_push_full_r10: assert property (@(posedge clk) disable iff (rst)
    push |-> !full_o);
  p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> nonempty);
endmodule

// File: rtl/pwf_commit_ctl.sv
module pwf_commit_ctl #(
  parameter int DEPTH  = 16,
  parameter int CW     = 5,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              eop,
  input  logic [ADDR_W-1:0] fifo_addr,
  input  logic              auto_en,
  input  logic [CW-1:0]     auto_len,
  input  logic [CW-1:0]     byte_cnt,
  input  logic              q_full,
  output logic              accept,
  output logic              commit,
  output logic [CW-1:0]     commit_len,
  output logic              overflow
);
  logic [CW-1:0] open_cnt;
  logic          guard;
  logic          hit, w_try, auto_hit, auto_fire, e_try, man_fire;

  always_comb begin
    hit        = sel && (fifo_addr == MY_ADDR);
    w_try      = hit && wr_en;
    auto_hit   = auto_en && (({1'b0, open_cnt} + (CW+1)'(1)) == {1'b0, auto_len});
    accept     = w_try && (byte_cnt < CW'(DEPTH)) && !(auto_hit && q_full);
    auto_fire  = accept && auto_hit;
    e_try      = hit && eop && !guard && !auto_fire;
    man_fire   = e_try && !q_full;
    commit     = auto_fire || man_fire;
    commit_len = auto_fire ? auto_len : open_cnt + CW'(accept);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_cnt <= '0;
      guard    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (commit)      open_cnt <= '0;
      else if (accept) open_cnt <= open_cnt + CW'(1);
      guard <= auto_fire;
      if ((w_try && !accept) || (e_try && q_full)) overflow <= 1'b1;
    end
  end

  p_guard_blocks_eop_r7: assert property (@(posedge clk) disable iff (rst)
    auto_fire |=> !man_fire);
  p_auto_clears_open_r6: assert property (@(posedge clk) disable iff (rst)
    auto_fire |=> (open_cnt == '0));
  p_sticky_ovf_r3: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  p_no_write_full_r3: assert property (@(posedge clk) disable iff (rst)
    (byte_cnt == CW'(DEPTH)) |-> !accept);
endmodule

// File: rtl/pkt_wr_fifo.sv
module pkt_wr_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int PKT_Q  = 4,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              sel,
  input  logic                              wr_en,
  input  logic                              eop,
  input  logic [ADDR_W-1:0]                 fifo_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic                              auto_en,
  input  logic [pwf_pkg::cnt_w(DEPTH)-1:0]  auto_len,
  input  logic                              out_ready,
  output logic                              out_valid,
  output logic [DATA_W-1:0]                 out_data,
  output logic                              out_last,
  output logic [pwf_pkg::cnt_w(DEPTH)-1:0]  out_count,
  output logic                              full,
  output logic                              empty,
  output logic                              overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = pwf_pkg::cnt_w(DEPTH);

  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count, offset;
  logic              accept, commit, q_full, zero_pkt, rd_byte, pkt_done;
  logic [CW-1:0]     commit_len, head_len;
  logic [DATA_W-1:0] rdata;

  pwf_commit_ctl #(.DEPTH(DEPTH), .CW(CW), .ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR)) u_ctl (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .eop(eop),
    .fifo_addr(fifo_addr), .auto_en(auto_en), .auto_len(auto_len),
    .byte_cnt(count), .q_full(q_full), .accept(accept), .commit(commit),
    .commit_len(commit_len), .overflow(overflow)
  );

  pwf_byte_ram #(.DW(DATA_W), .AW(AW)) u_ram (
    .clk(clk), .we(accept), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(rdata)
  );

  pwf_len_queue #(.LW(CW), .QD(PKT_Q)) u_lenq (
    .clk(clk), .rst(rst), .push(commit), .push_len(commit_len),
    .pop(pkt_done), .head_len(head_len), .nonempty(out_valid), .full_o(q_full)
  );

  always_comb begin
    zero_pkt  = (head_len == '0);
    out_last  = zero_pkt || (offset == head_len - CW'(1));
    out_count = head_len;
    out_data  = zero_pkt ? '0 : rdata;
    rd_byte   = out_valid && out_ready && !zero_pkt;
    pkt_done  = out_valid && out_ready && out_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      offset <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (accept)  wr_ptr <= wr_ptr + AW'(1);
      if (rd_byte) rd_ptr <= rd_ptr + AW'(1);
      count <= count + CW'(accept) - CW'(rd_byte);
      if (pkt_done)     offset <= '0;
      else if (rd_byte) offset <= offset + CW'(1);
      full  <= (count == CW'(DEPTH));
      empty <= (count == '0);
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  p_full_lag_r8: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH)) |=> full);
  p_empty_lag_r8: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |=> !empty);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
      && $stable(out_count) && $stable(out_last)));
endmodule

// File: tb/test_pkt_wr_fifo.sv
module test_pkt_wr_fifo;
  localparam int DEPTH = 8;
  localparam int QD    = 2;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1;
  logic sel = 0, wr_en = 0, eop = 0, auto_en = 0, out_ready = 0;
  logic [1:0] fifo_addr = 0;
  logic [7:0] wr_data = 0;
  logic [CW-1:0] auto_len = 0;
  logic out_valid, out_last, full, empty, overflow;
  logic [7:0] out_data;
  logic [CW-1:0] out_count;

  always #4 clk = ~clk;

  pkt_wr_fifo #(.DATA_W(8), .DEPTH(DEPTH), .PKT_Q(QD), .ADDR_W(2), .MY_ADDR(2'd2)) i_pkt_wr_fifo (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .eop(eop), .fifo_addr(fifo_addr),
    .wr_data(wr_data), .auto_en(auto_en), .auto_len(auto_len), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_count(out_count),
    .full(full), .empty(empty), .overflow(overflow)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  string ph = "R8";

  // behavioural reference
  int m_cnt, m_open, m_off;
  bit m_guard, m_ovf, m_full, m_empty;
  logic [7:0] mq[$];
  int dq[$];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_open = 0; m_off = 0; m_guard = 0; m_ovf = 0;
      m_full = 0; m_empty = 1; mq.delete(); dq.delete();
    end else begin
      int pre, clen;
      bit dfull, hit, wtry, ahit, acc, afire, etry, mfire;
      pre   = m_cnt;
      dfull = (dq.size() == QD);
      hit   = sel && (fifo_addr == 2'd2);
      wtry  = hit && wr_en;
      ahit  = auto_en && (m_open + 1 == int'(auto_len));
      acc   = wtry && (pre < DEPTH) && !(ahit && dfull);
      afire = acc && ahit;
      etry  = hit && eop && !m_guard && !afire;
      mfire = etry && !dfull;
      if ((wtry && !acc) || (etry && dfull)) m_ovf = 1;
      clen = afire ? int'(auto_len) : m_open + int'(acc);
      if (dq.size() > 0 && out_ready) begin
        if (dq[0] == 0) void'(dq.pop_front());
        else begin
          void'(mq.pop_front());
          m_cnt--;
          if (m_off == dq[0] - 1) begin void'(dq.pop_front()); m_off = 0; end
          else m_off++;
        end
      end
      if (acc) begin mq.push_back(wr_data); m_cnt++; end
      if (afire || mfire) begin dq.push_back(clen); m_open = 0; end
      else if (acc) m_open++;
      m_guard = afire;
      m_full  = (pre == DEPTH);
      m_empty = (pre == 0);
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: got %0d expected %0d (t=%0t)", req, ph, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R9", "out_valid", int'(out_valid), int'(dq.size() > 0));
      chk("R8", "full", int'(full), int'(m_full));
      chk("R8", "empty", int'(empty), int'(m_empty));
      chk("R3", "overflow", int'(overflow), int'(m_ovf));
      if (out_valid && dq.size() > 0) begin
        chk(ph, "out_count", int'(out_count), dq[0]);
        chk(ph, "out_last", int'(out_last), int'(dq[0] == 0 || m_off == dq[0] - 1));
        if (dq[0] != 0) chk(ph, "out_data", int'(out_data), int'(mq[0]));
      end
    end
  end

  task automatic drv(input bit s, input bit w, input bit e, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    sel = s; wr_en = w; eop = e; fifo_addr = a; wr_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(0, 0, 0, 2'd2, 8'h00);
  endtask

  task automatic do_reset();
    @(negedge clk); #1; rst = 1; sel = 0; wr_en = 0; eop = 0;
    repeat (2) @(negedge clk);
    #1 rst = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    ph = "R8"; idle(2);
    // R1 / R4: single write, then a burst of 3 with eop on the last byte
    ph = "R4"; out_ready = 1;
    drv(1, 1, 0, 2'd2, 8'h11); idle(1);
    ph = "R1";
    drv(1, 1, 0, 2'd2, 8'h21); drv(1, 1, 0, 2'd2, 8'h22);
    ph = "R4"; drv(1, 1, 1, 2'd2, 8'h23); idle(6);
    // R4: eop several cycles after the last byte
    drv(1, 1, 0, 2'd2, 8'h31); drv(1, 1, 0, 2'd2, 8'h32); idle(3);
    drv(1, 0, 1, 2'd2, 8'h00); idle(4);
    // R2: wrong address and deselected strobes
    ph = "R2";
    drv(1, 1, 0, 2'd1, 8'h41); drv(0, 1, 1, 2'd2, 8'h42); drv(1, 1, 1, 2'd3, 8'h43); idle(3);
    // R5: eop with nothing open
    ph = "R5"; drv(1, 0, 1, 2'd2, 8'h00); idle(3);
    // R6 / R7: auto packets of 4, eop on the commit edge and the next edge, then a 1-byte packet
    ph = "R6"; auto_en = 1; auto_len = CW'(4);
    drv(1, 1, 0, 2'd2, 8'h51); drv(1, 1, 0, 2'd2, 8'h52); drv(1, 1, 0, 2'd2, 8'h53);
    ph = "R7"; drv(1, 1, 1, 2'd2, 8'h54); drv(1, 0, 1, 2'd2, 8'h00); idle(2);
    drv(1, 1, 0, 2'd2, 8'h61); drv(1, 0, 1, 2'd2, 8'h00); idle(6);
    // R7: byte right after an auto packet with eop on the next (guarded) edge, eop again later
    drv(1, 1, 0, 2'd2, 8'h71); drv(1, 1, 0, 2'd2, 8'h72); drv(1, 1, 0, 2'd2, 8'h73);
    drv(1, 1, 0, 2'd2, 8'h74); drv(1, 1, 1, 2'd2, 8'h75); idle(1);
    drv(1, 0, 1, 2'd2, 8'h00); idle(6);
    auto_en = 0;
    // R10: packet queue full with a stalled consumer
    ph = "R10"; out_ready = 0;
    drv(1, 0, 1, 2'd2, 8'h00); drv(1, 0, 1, 2'd2, 8'h00); drv(1, 1, 1, 2'd2, 8'h81); idle(3);
    ph = "R9"; out_ready = 1; idle(4);
    drv(1, 0, 1, 2'd2, 8'h00); idle(3);
    // R3: fill beyond DEPTH while stalled
    do_reset();
    ph = "R3"; out_ready = 0;
    for (int i = 0; i < DEPTH + 3; i++) drv(1, 1, 0, 2'd2, 8'(8'h90 + i));
    idle(2);
    drv(1, 0, 1, 2'd2, 8'h00); idle(2);
    // R9: drain with back-pressure toggling
    ph = "R9";
    for (int i = 0; i < 24; i++) begin
      @(negedge clk); #1 out_ready = i[0] ^ i[2];
    end
    // R9: random mixed traffic
    do_reset();
    for (int i = 0; i < 400; i++) begin
      out_ready = ($urandom % 3) != 0;
      auto_en = (i >= 200);
      auto_len = CW'(1 + ($urandom % 5));
      if (auto_en) auto_len = CW'(3);
      drv(($urandom % 8) != 0, ($urandom % 2) == 1, ($urandom % 6) == 0,
          (($urandom % 5) == 0) ? 2'd0 : 2'd2, 8'($urandom));
    end
    auto_en = 0; out_ready = 1; idle(4);
    drv(1, 0, 1, 2'd2, 8'h00); idle(30);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule